// File: doc/BRIEF.md
# Translation Context Quadrant Decoder

This block is the first step of address translation. For each request it takes a 64-bit effective address, the hypervisor-mode flag, the relocation flag, the kind of access, the current partition and process identifiers, and the hypervisor real-mode offset. It then does one of three things. It can produce the partition and process IDs that the table walk must use. It can raise a segment fault. Or, in hypervisor real mode, it can form the real address directly and skip translation.

The two most significant address bits select one of four quadrants. The hypervisor and the guest map the quadrants differently, and the guest treats two of them as illegal. A segment fault on a data access records the address that caused it. A segment fault on an instruction fetch records only that the fault was on the instruction side.

The response appears one clock after the request strobe. A parameter can remove the output register so that the response is combinational.

Top module: `xctx_decoder`

## Requirements
- R1: `rspValid` pulses high exactly one clock after a cycle with `reqValid` high, and stays low after a cycle without a request. All result outputs keep their values until the next response.
- R2: This applies outside the real-mode bypass of R8. If any of address bits 61 down to 52 is set, the response is a segment fault: `segFault`=1, `ctxValid`=0, and both ID outputs are 0.
- R3: Hypervisor mode (`hvMode`=1) with a legal address, quadrant `ea[63:62]`=0: partition ID 0 and the current process ID. Quadrant 1: the current partition ID and the current process ID.
- R4: Hypervisor mode, quadrant 2: the current partition ID and process ID 0. Quadrant 3: partition ID 0 and process ID 0.
- R5: Guest mode (`hvMode`=0), quadrant 0: the current partition ID and the current process ID. Quadrant 3: the current partition ID and process ID 0.
- R6: Guest mode, quadrant 1 or 2: a segment fault, with both ID outputs 0.
- R7: `accType` uses 0 for an instruction fetch, 1 for a load and 2 for a store; any nonzero value counts as a data access. On a data segment fault, `faultAddr` takes the effective address and `faultIsInstr`=0. On a fetch segment fault, `faultIsInstr`=1 and `faultAddr` is left unchanged. `faultIsInstr` is 0 in every response that is not a fault.
- R8: When `relocOn`=0 and `hvMode`=1, the block bypasses translation. The response has `realValid`=1, `ctxValid`=0 and `segFault`=0, and both IDs are 0. `permRwx` is 3'b111, where bit 2 is read, bit 1 is write and bit 0 is execute. The real address is the effective address with bits 63:60 cleared. Address bits 61:52 are ignored.
- R9: In the bypass, if `ea[63]`=0 then `hrmor` is ORed into the real address. If `ea[63]`=1 it is not.
- R10: After reset every output is 0. Every response raises exactly one of `ctxValid`, `realValid` and `segFault`. Outside the bypass, `realAddr` and `permRwx` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe |
| ea | input | 64 | Effective address |
| accType | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| hvMode | input | 1 | Hypervisor mode flag |
| relocOn | input | 1 | Relocation enabled |
| curPartId | input | 12 | Current partition identifier |
| curProcId | input | 20 | Current process identifier |
| hrmor | input | 64 | Hypervisor real-mode offset |
| rspValid | output | 1 | Response strobe |
| ctxValid | output | 1 | IDs are valid for a table walk |
| partIdOut | output | 12 | Partition ID to use |
| procIdOut | output | 20 | Process ID to use |
| realValid | output | 1 | Real-mode bypass result |
| realAddr | output | 64 | Bypass real address |
| permRwx | output | 3 | Bypass permissions: read, write, execute |
| segFault | output | 1 | Segment fault |
| faultIsInstr | output | 1 | Fault was on an instruction fetch |
| faultAddr | output | 64 | Address of the last data segment fault |

## Verification
The properties assume that `reqValid` is low while reset is asserted. They also assume that `hrmor` never sets bits 63:60, so that a cleared top nibble in the bypass can be observed. The bench holds `hrmor` at a value whose set bits all lie below bit 60, and it raises requests only after reset has been released. The request sweep covers every combination of mode, relocation, quadrant, access kind and three patterns of the reserved bits. Every request is single-cycle and is followed by an idle cycle, so each response can be checked against one stimulus.

// File: rtl/xctx_pkg.sv
package xctx_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_e;

  // Strobes from control to datapath, valid in the request cycle
  typedef struct packed {
    logic capture;     // register a response
    logic bypass;      // real-mode path
    logic fault;       // segment fault
    logic faultInstr;  // fault is on the fetch side
    logic latchAddr;   // record faulting address
    logic keepPart;    // pass current partition ID
    logic keepProc;    // pass current process ID
  } ctl_strobe_t;

endpackage

// File: rtl/xctx_ctrl.sv
module xctx_ctrl
  import xctx_pkg::*;
(
  input  logic        reqValid,
  input  logic        hvMode,
  input  logic        relocOn,
  input  logic [1:0]  accType,
  input  logic [1:0]  quad,
  input  logic        rsvHit,
  output ctl_strobe_t strobe
);

  logic legal;
  logic keepPart;
  logic keepProc;
  logic bypass;
  logic fault;
  logic isFetch;

  // Quadrant map differs between hypervisor and guest
  always_comb begin
    legal    = 1'b1;
    keepPart = 1'b0;
    keepProc = 1'b0;
    unique case ({hvMode, quad})
      3'b1_00: begin keepPart = 1'b0; keepProc = 1'b1; end
      3'b1_01: begin keepPart = 1'b1; keepProc = 1'b1; end
      3'b1_10: begin keepPart = 1'b1; keepProc = 1'b0; end
      3'b1_11: begin keepPart = 1'b0; keepProc = 1'b0; end
      3'b0_00: begin keepPart = 1'b1; keepProc = 1'b1; end
      3'b0_11: begin keepPart = 1'b1; keepProc = 1'b0; end
      default: legal = 1'b0;
    endcase
  end

  assign bypass  = hvMode && !relocOn;
  assign fault   = !bypass && (rsvHit || !legal);
  assign isFetch = (accType == ACC_FETCH);

  always_comb begin
    strobe            = '0;
    strobe.capture    = reqValid;
    strobe.bypass     = bypass;
    strobe.fault      = fault;
    strobe.faultInstr = fault && isFetch;
    strobe.latchAddr  = reqValid && fault && !isFetch;
    strobe.keepPart   = keepPart;
    strobe.keepProc   = keepProc;
  end

endmodule

// File: rtl/xctx_datapath.sv
module xctx_datapath
  import xctx_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int PART_W = 12,
  parameter int PROC_W = 20,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_strobe_t       strobe,
  input  logic [ADDR_W-1:0] ea,
  input  logic [PART_W-1:0] curPartId,
  input  logic [PROC_W-1:0] curProcId,
  input  logic [ADDR_W-1:0] hrmor,
  output logic [1:0]        quad,
  output logic              rsvHit,
  output logic              rspValid,
  output logic              ctxValid,
  output logic [PART_W-1:0] partIdOut,
  output logic [PROC_W-1:0] procIdOut,
  output logic              realValid,
  output logic [ADDR_W-1:0] realAddr,
  output logic [2:0]        permRwx,
  output logic              segFault,
  output logic              faultIsInstr,
  output logic [ADDR_W-1:0] faultAddr
);

  localparam int QUAD_LSB = ADDR_W - 2;
  localparam int RSV_HI   = ADDR_W - 3;
  localparam int RSV_LSB  = ADDR_W - 12;
  localparam int CLR_W    = 4;
  localparam int KEEP_W   = ADDR_W - CLR_W;

  logic              nCtx;
  logic [PART_W-1:0] nPart;
  logic [PROC_W-1:0] nProc;
  logic [ADDR_W-1:0] realBase;
  logic [ADDR_W-1:0] nReal;
  logic [2:0]        nPerm;
  logic [ADDR_W-1:0] faultAddrQ;

  assign quad   = ea[ADDR_W-1:QUAD_LSB];
  assign rsvHit = |ea[RSV_HI:RSV_LSB];

  assign nCtx     = !strobe.bypass && !strobe.fault;
  assign nPart    = (nCtx && strobe.keepPart) ? curPartId : '0;
  assign nProc    = (nCtx && strobe.keepProc) ? curProcId : '0;
  assign realBase = {{CLR_W{1'b0}}, ea[KEEP_W-1:0]};
  assign nReal    = strobe.bypass ?
                    (realBase | (ea[ADDR_W-1] ? '0 : hrmor)) : '0;
  assign nPerm    = strobe.bypass ? 3'b111 : 3'b000;

  // Fault address record: updated only by data-side faults
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) faultAddrQ <= '0;
    else if (strobe.latchAddr) faultAddrQ <= ea;
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          rspValid     <= 1'b0;
          ctxValid     <= 1'b0;
          partIdOut    <= '0;
          procIdOut    <= '0;
          realValid    <= 1'b0;
          realAddr     <= '0;
          permRwx      <= '0;
          segFault     <= 1'b0;
          faultIsInstr <= 1'b0;
        end else begin
          rspValid <= strobe.capture;
          if (strobe.capture) begin
            ctxValid     <= nCtx;
            partIdOut    <= nPart;
            procIdOut    <= nProc;
            realValid    <= strobe.bypass;
            realAddr     <= nReal;
            permRwx      <= nPerm;
            segFault     <= strobe.fault;
            faultIsInstr <= strobe.faultInstr;
          end
        end
      end
      assign faultAddr = faultAddrQ;
    end else begin : g_comb
      assign rspValid     = strobe.capture;
      assign ctxValid     = nCtx;
      assign partIdOut    = nPart;
      assign procIdOut    = nProc;
      assign realValid    = strobe.bypass;
      assign realAddr     = nReal;
      assign permRwx      = nPerm;
      assign segFault     = strobe.fault;
      assign faultIsInstr = strobe.faultInstr;
      assign faultAddr    = strobe.latchAddr ? ea : faultAddrQ;
    end
  endgenerate

endmodule

// File: rtl/xctx_decoder.sv
module xctx_decoder
  import xctx_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int PART_W = 12,
  parameter int PROC_W = 20,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] ea,
  input  logic [1:0]        accType,
  input  logic              hvMode,
  input  logic              relocOn,
  input  logic [PART_W-1:0] curPartId,
  input  logic [PROC_W-1:0] curProcId,
  input  logic [ADDR_W-1:0] hrmor,
  output logic              rspValid,
  output logic              ctxValid,
  output logic [PART_W-1:0] partIdOut,
  output logic [PROC_W-1:0] procIdOut,
  output logic              realValid,
  output logic [ADDR_W-1:0] realAddr,
  output logic [2:0]        permRwx,
  output logic              segFault,
  output logic              faultIsInstr,
  output logic [ADDR_W-1:0] faultAddr
);

  ctl_strobe_t strobe;
  logic [1:0]  quad;
  logic        rsvHit;

  xctx_ctrl u_ctrl (
    .reqValid (reqValid),
    .hvMode   (hvMode),
    .relocOn  (relocOn),
    .accType  (accType),
    .quad     (quad),
    .rsvHit   (rsvHit),
    .strobe   (strobe)
  );

  xctx_datapath #(
    .ADDR_W  (ADDR_W),
    .PART_W  (PART_W),
    .PROC_W  (PROC_W),
    .REG_OUT (REG_OUT)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .ea           (ea),
    .curPartId    (curPartId),
    .curProcId    (curProcId),
    .hrmor        (hrmor),
    .quad         (quad),
    .rsvHit       (rsvHit),
    .rspValid     (rspValid),
    .ctxValid     (ctxValid),
    .partIdOut    (partIdOut),
    .procIdOut    (procIdOut),
    .realValid    (realValid),
    .realAddr     (realAddr),
    .permRwx      (permRwx),
    .segFault     (segFault),
    .faultIsInstr (faultIsInstr),
    .faultAddr    (faultAddr)
  );

endmodule

// File: rtl/xctx_decoder_chk.sv
module xctx_decoder_chk #(
  parameter int ADDR_W = 64,
  parameter int PART_W = 12,
  parameter int PROC_W = 20,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] ea,
  input logic [1:0]        accType,
  input logic              hvMode,
  input logic              relocOn,
  input logic [ADDR_W-1:0] hrmor,
  input logic              rspValid,
  input logic              ctxValid,
  input logic [PART_W-1:0] partIdOut,
  input logic [PROC_W-1:0] procIdOut,
  input logic              realValid,
  input logic [ADDR_W-1:0] realAddr,
  input logic [2:0]        permRwx,
  input logic              segFault,
  input logic              faultIsInstr,
  input logic [ADDR_W-1:0] faultAddr
);

  localparam int TOP    = ADDR_W - 1;
  localparam int QLO    = ADDR_W - 2;
  localparam int RSV_HI = ADDR_W - 3;
  localparam int RSV_LO = ADDR_W - 12;
  localparam int NIB_LO = ADDR_W - 4;

  generate
    if (REG_OUT) begin : g_props
      p_one_cycle_r1: assert property (@(posedge clk) disable iff (!rstN)
        reqValid |=> rspValid);

      p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rstN)
        !reqValid |=> !rspValid);

      p_one_kind_r10: assert property (@(posedge clk) disable iff (!rstN)
        rspValid |-> ($countones({ctxValid, realValid, segFault}) == 1));

      p_rsv_fault_r2: assert property (@(posedge clk) disable iff (!rstN)
        (reqValid && !(hvMode && !relocOn) && (ea[RSV_HI:RSV_LO] != '0))
        |=> (segFault && partIdOut == '0 && procIdOut == '0));

      p_guest_illegal_r6: assert property (@(posedge clk) disable iff (!rstN)
        (reqValid && !hvMode && (ea[TOP] != ea[QLO])) |=> segFault);

      p_data_addr_r7: assert property (@(posedge clk) disable iff (!rstN)
        (reqValid && accType != 2'd0)
        |=> (!segFault || (faultAddr == $past(ea) && !faultIsInstr)));

      p_fetch_keep_r7: assert property (@(posedge clk) disable iff (!rstN)
        (reqValid && accType == 2'd0) |=> $stable(faultAddr));

      p_bypass_r8: assert property (@(posedge clk) disable iff (!rstN)
        (reqValid && hvMode && !relocOn)
        |=> (realValid && permRwx == 3'b111 && !segFault));

      p_bypass_nibble_r8: assert property (@(posedge clk) disable iff (!rstN)
        (reqValid && hvMode && !relocOn && ea[TOP])
        |=> (realAddr[TOP:NIB_LO] == '0));

      p_offset_r9: assert property (@(posedge clk) disable iff (!rstN)
        (reqValid && hvMode && !relocOn && !ea[TOP])
        |=> ((realAddr & $past(hrmor)) == $past(hrmor)));
    end
  endgenerate

endmodule

bind xctx_decoder xctx_decoder_chk #(
  .ADDR_W  (ADDR_W),
  .PART_W  (PART_W),
  .PROC_W  (PROC_W),
  .REG_OUT (REG_OUT)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .ea           (ea),
  .accType      (accType),
  .hvMode       (hvMode),
  .relocOn      (relocOn),
  .hrmor        (hrmor),
  .rspValid     (rspValid),
  .ctxValid     (ctxValid),
  .partIdOut    (partIdOut),
  .procIdOut    (procIdOut),
  .realValid    (realValid),
  .realAddr     (realAddr),
  .permRwx      (permRwx),
  .segFault     (segFault),
  .faultIsInstr (faultIsInstr),
  .faultAddr    (faultAddr)
);

// File: tb/xctx_decoder_tb.sv
`timescale 1ns/1ps
module xctx_decoder_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [63:0] ea = '0;
  logic [1:0]  accType = '0;
  logic        hvMode = 1'b0;
  logic        relocOn = 1'b0;
  logic [11:0] curPartId = 12'hA5C;
  logic [19:0] curProcId = 20'h31F7E;
  logic [63:0] hrmor = 64'h0000_0000_4000_0000;
  logic        rspValid, ctxValid, realValid, segFault, faultIsInstr;
  logic [11:0] partIdOut;
  logic [19:0] procIdOut;
  logic [63:0] realAddr, faultAddr;
  logic [2:0]  permRwx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [63:0] expFaultAddr = '0;

  always #2.5 clk = ~clk;

  xctx_decoder u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .ea(ea), .accType(accType),
    .hvMode(hvMode), .relocOn(relocOn), .curPartId(curPartId),
    .curProcId(curProcId), .hrmor(hrmor), .rspValid(rspValid),
    .ctxValid(ctxValid), .partIdOut(partIdOut), .procIdOut(procIdOut),
    .realValid(realValid), .realAddr(realAddr), .permRwx(permRwx),
    .segFault(segFault), .faultIsInstr(faultIsInstr), .faultAddr(faultAddr)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One request, then the response is checked in the following cycle
  task automatic runReq(input bit hv, input bit rel, input logic [63:0] addr,
                        input logic [1:0] acc);
    bit byp, flt, ctx;
    logic [11:0] eP;
    logic [19:0] eQ;
    logic [63:0] eR;
    string tag;
    @(negedge clk);
    hvMode = hv; relocOn = rel; ea = addr; accType = acc; reqValid = 1'b1;
    byp = hv && !rel;
    flt = 1'b0; eP = '0; eQ = '0; eR = '0;
    tag = "R3";
    if (byp) begin
      tag = addr[63] ? "R8" : "R9";
      eR = {4'b0000, addr[59:0]} | (addr[63] ? 64'd0 : hrmor);
    end else if (addr[61:52] != 10'd0) begin
      flt = 1'b1; tag = "R2";
    end else if (hv) begin
      tag = addr[63] ? "R4" : "R3";
      eP = addr[62] ^ addr[63] ? curPartId : 12'd0;
      eQ = addr[63] ? 20'd0 : curProcId;
    end else begin
      case (addr[63:62])
        2'd0: begin eP = curPartId; eQ = curProcId; tag = "R5"; end
        2'd3: begin eP = curPartId; eQ = 20'd0;     tag = "R5"; end
        default: begin flt = 1'b1; tag = "R6"; end
      endcase
    end
    ctx = !byp && !flt;
    if (flt && acc != 2'd0) expFaultAddr = addr;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R1", "rspValid", 64'(rspValid), 64'd1);
    chk(tag, "ctxValid", 64'(ctxValid), 64'(ctx));
    chk(tag, "realValid", 64'(realValid), 64'(byp));
    chk(tag, "segFault", 64'(segFault), 64'(flt));
    chk(tag, "partId", 64'(partIdOut), 64'(eP));
    chk(tag, "procId", 64'(procIdOut), 64'(eQ));
    chk(byp ? tag : "R10", "realAddr", realAddr, eR);
    chk(byp ? "R8" : "R10", "permRwx", 64'(permRwx), byp ? 64'd7 : 64'd0);
    chk("R7", "faultIsInstr", 64'(faultIsInstr), 64'(flt && acc == 2'd0));
    chk("R7", "faultAddr", faultAddr, expFaultAddr);
    // R1: no new response, results hold
    @(negedge clk);
    chk("R1", "rspValid idle", 64'(rspValid), 64'd0);
    chk("R1", "hold segFault", 64'(segFault), 64'(flt));
    chk("R1", "hold partId", 64'(partIdOut), 64'(eP));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "reset rspValid", 64'(rspValid), 64'd0);
    chk("R10", "reset ctxValid", 64'(ctxValid), 64'd0);
    chk("R10", "reset realAddr", realAddr, 64'd0);
    chk("R10", "reset faultAddr", faultAddr, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    for (int h = 0; h < 2; h++)
      for (int r = 0; r < 2; r++)
        for (int q = 0; q < 4; q++)
          for (int s = 0; s < 3; s++)
            for (int a = 0; a < 3; a++) begin
              logic [9:0] rsv;
              logic [51:0] low;
              rsv = (s == 0) ? 10'd0 : (s == 1) ? 10'h001 : 10'h200;
              low = 52'h1_2345_6789_ABCD ^ 52'(h * 1000 + r * 100 + q * 10 + s + a * 7);
              runReq(h[0], r[0], {q[1:0], rsv, low}, a[1:0]);
            end
    // Fetch fault after a data fault keeps the recorded address (R7)
    runReq(1'b0, 1'b1, 64'h4000_0000_0000_1110, 2'd2);
    runReq(1'b0, 1'b1, 64'h8000_0000_0000_2220, 2'd0);
    // Unusual access code treated as data (R7)
    runReq(1'b1, 1'b1, 64'h0010_0000_0000_3330, 2'd3);
    // Bypass with all-ones address, high bit set and clear (R8, R9)
    runReq(1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 2'd1);
    runReq(1'b1, 1'b0, 64'h7FF0_0000_0000_0000, 2'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule